// File: doc/BRIEF.md
# I2C Command-Pointer Register Target

This block is an I2C target that lets one upstream controller reach three byte-wide registers: an interrupt-enable register, a control register and a read-only interrupt status value. A system clock oversamples SCL and SDA. The block detects START and STOP and answers a 7-bit address built from a fixed `111` prefix and four strap pins. SDA is open-drain. The block only pulls the line low, through an output-enable.

After its address with a write direction, the first byte is a command. The command holds a 2-bit register pointer and an auto-increment flag. Every following data byte, and every read in later transactions, uses that pointer. When the flag is set, the pointer advances after each data byte, and how it advances depends on the direction. Reads roll over to the first register. Writes stop at the read-only register, and bytes sent there are refused. The interrupt-enable and control values are output ports, and the status value is an input port.

Top module: `i2c_cmd_regif`

## Requirements
- R1: The block acknowledges only the address `{3'b111, strap_i[3:0]}` in bits 7..1 of the first byte after START. Bit 0 is the direction: 1 means read and 0 means write. On any other address it does not acknowledge, and it ignores every byte until the next START.
- R2: After an acknowledged write address, the next byte is acknowledged and stored as the command. Bit 4 of the command is the auto-increment flag and bits 1..0 are the pointer: 0 selects IE, 1 selects CONTROL and 2 selects ISTAT.
- R3: A command byte other than `000a0000`, `000a0001` or `000a0010` (where a is any value of bit 4) is not acknowledged, and the stored command keeps its old value.
- R4: Data bytes written while the pointer is 0 or 1 are acknowledged and appear on `ie_o` or `ctrl_o`.
- R5: With auto-increment clear, the pointer never moves, so successive bytes in either direction access the same register.
- R6: Read data is sent MSB first. With auto-increment set, the read pointer advances 0→1→2→0. The ISTAT value is taken from `istat_i` when each read byte is loaded.
- R7: A data byte written while the pointer is 2 is not acknowledged and not stored, and the pointer stays at 2.
- R8: After reset the command (pointer and flag), `ie_o` and `ctrl_o` are all zero.
- R9: The block changes SDA only while SCL is low. It pulls SDA low for an acknowledge during the ninth clock of a byte.
- R10: When the controller does not acknowledge a read byte, the block releases SDA until STOP or START. A repeated START begins a new address phase and keeps the stored command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock as seen on the line |
| sda_i | input | 1 | Bus data as seen on the line |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain) |
| strap_i | input | 4 | Low four address bits from strap pins |
| istat_i | input | 8 | Interrupt status value returned at pointer 2 |
| ie_o | output | 8 | Interrupt-enable register contents |
| ctrl_o | output | 8 | Control register contents |

## Verification
Some properties are checked by assertions on every cycle. The pointer never holds the illegal value 3. No write is issued to the status register. A read at pointer 2 with auto-increment set wraps the pointer to 0, and without auto-increment a read leaves the pointer in place. The output-enable rises only while the synchronized SCL is low, and SDA is released while the block waits after a refused byte. The bench scenarios cover what depends on whole byte sequences: address matching against the straps, rejection of each illegal command shape, the write pointer sticking at the status register, sampling of the status input byte by byte, and keeping the command across a repeated START.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2;
  localparam int STRAP_W = 4;
  localparam logic [2:0] ADDR_FIXED = 3'b111;

  localparam logic [PTR_W-1:0] PTR_IE    = 2'd0;
  localparam logic [PTR_W-1:0] PTR_CTRL  = 2'd1;
  localparam logic [PTR_W-1:0] PTR_ISTAT = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } bus_state_e;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_CMD,
    RX_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  // data edges qualify only with SCL high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
endmodule

// File: rtl/i2c_cmd_regs.sv
module i2c_cmd_regs
  import i2c_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cmd_we_i,
  input  logic              wr_en_i,
  input  logic              rd_adv_i,
  input  logic [BYTE_W-1:0] istat_i,
  output logic              cmd_ok_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] ie_o,
  output logic [BYTE_W-1:0] ctrl_o
);
  logic             ai_q;
  logic [PTR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] ie_q, ctrl_q;

  assign cmd_ok_o = (byte_i[7:5] == 3'b000) && (byte_i[3:2] == 2'b00) &&
                    (byte_i[1:0] != 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ai_q   <= 1'b0;
      ptr_q  <= PTR_IE;
      ie_q   <= '0;
      ctrl_q <= '0;
    end else if (cmd_we_i) begin
      ai_q  <= byte_i[4];
      ptr_q <= byte_i[PTR_W-1:0];
    end else if (wr_en_i) begin
      if (ptr_q == PTR_IE) ie_q <= byte_i;
      else                 ctrl_q <= byte_i;
      // write side saturates at the read-only slot
      if (ai_q && ptr_q != PTR_ISTAT) ptr_q <= ptr_q + 2'd1;
    end else if (rd_adv_i && ai_q) begin
      ptr_q <= (ptr_q == PTR_ISTAT) ? PTR_IE : ptr_q + 2'd1;
    end
  end

  always_comb begin
    unique case (ptr_q)
      PTR_IE:    rd_data_o = ie_q;
      PTR_CTRL:  rd_data_o = ctrl_q;
      PTR_ISTAT: rd_data_o = istat_i;
      default:   rd_data_o = '0;
    endcase
  end

  assign ptr_o  = ptr_q;
  assign ie_o   = ie_q;
  assign ctrl_o = ctrl_q;

  AST_PTR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q != 2'b11); // R3
  AST_NO_ISTAT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && ptr_q == PTR_ISTAT)); // R7
  AST_RD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_adv_i && ai_q && ptr_q == PTR_ISTAT) |=> ptr_q == PTR_IE); // R6
  AST_NOAI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_adv_i && !ai_q) |=> $stable(ptr_q)); // R5
endmodule

// File: rtl/i2c_cmd_regif.sv
module i2c_cmd_regif
  import i2c_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0] istat_i,
  output logic [BYTE_W-1:0] ie_o,
  output logic [BYTE_W-1:0] ctrl_o
);
  logic scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_p), .stop_o(stop_p),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  bus_state_e        state_q;
  rx_kind_e          kind_q;
  logic [2:0]        bit_q;
  logic              done_q, rd_q, mack_q, oe_q;
  logic [BYTE_W-1:0] sh_q, tx_q;

  logic              cmd_ok, byte_end, ack_ok, cmd_we, wr_en, rd_adv;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rd_data;

  assign byte_end = (state_q == ST_RX) && scl_fall && done_q;

  always_comb begin
    unique case (kind_q)
      RX_ADDR: ack_ok = (sh_q[7:1] == {ADDR_FIXED, strap_i});
      RX_CMD:  ack_ok = cmd_ok;
      default: ack_ok = (ptr != PTR_ISTAT);
    endcase
  end

  assign cmd_we = byte_end && kind_q == RX_CMD && cmd_ok;
  assign wr_en  = byte_end && kind_q == RX_DATA && ptr != PTR_ISTAT;
  assign rd_adv = (state_q == ST_MACK) && scl_rise;

  i2c_cmd_regs u_regs (
    .clk_i, .rst_ni, .byte_i(sh_q), .cmd_we_i(cmd_we), .wr_en_i(wr_en),
    .rd_adv_i(rd_adv), .istat_i, .cmd_ok_o(cmd_ok), .ptr_o(ptr),
    .rd_data_o(rd_data), .ie_o, .ctrl_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= RX_ADDR;
      bit_q   <= '0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
    end else if (start_p) begin
      state_q <= ST_RX;
      kind_q  <= RX_ADDR;
      bit_q   <= '0;
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (stop_p) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) done_q <= 1'b1;
          end else if (byte_end) begin
            done_q <= 1'b0;
            bit_q  <= '0;
            if (kind_q == RX_ADDR) rd_q <= sh_q[0];
            if (ack_ok) begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (kind_q == RX_ADDR && rd_q) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              bit_q   <= '0;
              state_q <= ST_TX;
            end else begin
              oe_q    <= 1'b0;
              kind_q  <= (kind_q == RX_ADDR) ? RX_CMD : RX_DATA;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~tx_q[BYTE_W-2];
              bit_q <= bit_q + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              bit_q   <= '0;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && !$past(oe_q)) |-> !scl_s); // R9
  AST_WAIT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !sda_oe_o); // R10
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && $past(state_q) == ST_RX) |-> $past(done_q)); // R9
endmodule

// File: tb/i2c_cmd_regif_tb.sv
module i2c_cmd_regif_tb;
  localparam int Q = 10;
  localparam logic [3:0] STRAP = 4'b0110;
  localparam logic [6:0] ADDR7 = {3'b111, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [7:0] istat = 8'h00;
  logic [7:0] ie, ctrl;
  wire  sda_bus = sda_m & ~sda_oe;

  int total = 0, bad = 0, viol = 0;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  i2c_cmd_regif u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .istat_i(istat),
    .ie_o(ie), .ctrl_o(ctrl)
  );

  always @(posedge clk) begin
    if (rst_n && scl_m && sda_oe != oe_prev) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~mack);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] d;
    chk("R8 ie after reset", ie, 8'h00);
    chk("R8 ctrl after reset", ctrl, 8'h00);
    bus_start();
    put_byte({ADDR7, 1'b1}, a);
    chk("R1 read address ack", {7'd0, a}, 8'd1);
    get_byte(1'b1, d);
    chk("R8 reset pointer reads IE", d, 8'h00);
    get_byte(1'b0, d);
    chk("R5 R8 no increment after reset", d, 8'h00);
    bus_stop();
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    put_byte({7'b1110111, 1'b0}, a);
    chk("R1 wrong address nack", {7'd0, a}, 8'd0);
    put_byte(8'h10, a);
    chk("R1 ignored after mismatch", {7'd0, a}, 8'd0);
    put_byte(8'hFF, a);
    bus_stop();
    chk("R1 ie untouched", ie, 8'h00);
  endtask

  task automatic t_write_seq();
    logic a;
    bus_start();
    put_byte({ADDR7, 1'b0}, a);
    chk("R1 write address ack", {7'd0, a}, 8'd1);
    put_byte(8'h10, a);
    chk("R2 command ack", {7'd0, a}, 8'd1);
    put_byte(8'hA5, a);
    chk("R4 ie byte ack", {7'd0, a}, 8'd1);
    put_byte(8'h3C, a);
    chk("R4 ctrl byte ack", {7'd0, a}, 8'd1);
    put_byte(8'h77, a);
    chk("R7 istat write nack", {7'd0, a}, 8'd0);
    bus_stop();
    chk("R4 ie value", ie, 8'hA5);
    chk("R4 ctrl value", ctrl, 8'h3C);
  endtask

  task automatic t_read_wrap();
    logic a; logic [7:0] d;
    istat = 8'h5E;
    bus_start();
    put_byte({ADDR7, 1'b1}, a);
    get_byte(1'b1, d);
    chk("R7 pointer stuck at istat", d, 8'h5E);
    get_byte(1'b1, d);
    chk("R6 wrap to IE", d, 8'hA5);
    istat = 8'h81;
    get_byte(1'b1, d);
    chk("R6 then CTRL", d, 8'h3C);
    get_byte(1'b0, d);
    chk("R6 istat sampled per byte", d, 8'h81);
    bus_stop();
  endtask

  task automatic t_bad_cmd();
    logic a; logic [7:0] d;
    logic [7:0] bad_cmds [4] = '{8'h13, 8'h20, 8'h18, 8'h90};
    foreach (bad_cmds[i]) begin
      bus_start();
      put_byte({ADDR7, 1'b0}, a);
      put_byte(bad_cmds[i], a);
      chk("R3 illegal command nack", {7'd0, a}, 8'd0);
      bus_stop();
    end
    bus_start();
    put_byte({ADDR7, 1'b1}, a);
    get_byte(1'b0, d);
    chk("R3 command kept", d, 8'hA5);
    bus_stop();
  endtask

  task automatic t_no_ai();
    logic a; logic [7:0] d;
    bus_start();
    put_byte({ADDR7, 1'b0}, a);
    put_byte(8'h01, a);
    put_byte(8'h11, a);
    put_byte(8'h22, a);
    chk("R5 second write ack", {7'd0, a}, 8'd1);
    bus_stop();
    chk("R5 ctrl overwritten", ctrl, 8'h22);
    chk("R5 ie untouched", ie, 8'hA5);
    bus_start();
    put_byte({ADDR7, 1'b1}, a);
    get_byte(1'b1, d);
    chk("R5 read ctrl", d, 8'h22);
    get_byte(1'b0, d);
    chk("R5 read ctrl again", d, 8'h22);
    bus_stop();
  endtask

  task automatic t_rstart();
    logic a, b; logic [7:0] d;
    istat = 8'h42;
    bus_start();
    put_byte({ADDR7, 1'b0}, a);
    put_byte(8'h12, a);
    chk("R2 command to istat ack", {7'd0, a}, 8'd1);
    bus_start();
    put_byte({ADDR7, 1'b1}, a);
    chk("R10 address after repeated start", {7'd0, a}, 8'd1);
    get_byte(1'b0, d);
    chk("R6 istat read", d, 8'h42);
    get_bit(b);
    chk("R10 released after nack", {7'd0, b}, 8'd1);
    get_bit(b);
    chk("R10 still released", {7'd0, b}, 8'd1);
    bus_start();
    put_byte({ADDR7, 1'b1}, a);
    get_byte(1'b0, d);
    chk("R10 command kept over repeated start", d, 8'hA5);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_bad_addr();
    t_write_seq();
    t_read_wrap();
    t_bad_cmd();
    t_no_ai();
    t_rstart();
    chk("R9 sda change only with scl low", viol[7:0], 8'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule